// File: doc/BRIEF.md
# Processor Power-State Sequencer

This block tracks the clock-control power state of a processor core. It runs on the bus clock and takes several kinds of input: active-low requests to stop the core clock, to sleep and to reset; a strobe that marks the halt instruction; strobes that mark the start and the end of a bus snoop; a flag that says the bus clock is running; and five interrupt-type event pins. Every one of these inputs passes through a two-flop synchronizer before the state machine uses it. The outputs are the state in one-hot form, an enable for the internal core clock, an enable for snoop responses, a pending flag for each event, a one-cycle delivery pulse for each event, and a flag for protocol violations. Real clock gating, the PLL and the snoop machinery are not part of this block. Those parts act on the enables and strobes.

The six states are Normal, AutoHALT, Stop-Grant, Snoop (the halt/grant snoop state), Sleep and Deep Sleep. These are the transitions:

- Normal→Stop-Grant on a stop-clock request, and Stop-Grant→Normal when that request is released.
- Normal→AutoHALT on the halt strobe.
- AutoHALT→Normal when an event is pending.
- AutoHALT→Stop-Grant on a stop-clock request.
- Stop-Grant→Snoop and AutoHALT→Snoop on a snoop start.
- Snoop→origin on a snoop done. The origin is the state the snoop came from.
- Stop-Grant→Sleep on a sleep request.
- Sleep→Deep Sleep when the bus clock is lost, and Deep Sleep→Sleep when it returns.
- Sleep→Stop-Grant when the sleep request is released.
- Any state→Normal on a reset request, except Stop-Grant, which stays where it is.

Events that arrive outside the sleep states are held as pending. They are handed out once each, and only from Normal.

Top module: `pwr_state_seq`

## Requirements
- R1: `state_oh` is one-hot, with bit 0 Normal, bit 1 AutoHALT, bit 2 Stop-Grant, bit 3 Snoop, bit 4 Sleep and bit 5 Deep Sleep. After `arst_n` the block is in Normal, with no pending events, no deliveries and no violation.
- R2: The stop-clock request moves Normal to Stop-Grant, and its release moves Stop-Grant back to Normal. An input change takes effect at the third rising clock edge after it is applied.
- R3: `core_clk_en` is high only in Normal and AutoHALT. `snoop_resp_en` is high only in Stop-Grant, AutoHALT and Snoop.
- R4: A snoop start in Stop-Grant or AutoHALT enters Snoop. The block stays in Snoop until a snoop done, then returns to the state it came from.
- R5: Sleep is entered only from Stop-Grant, on the sleep request. A sleep request seen in Normal, AutoHALT or Snoop pulses `proto_violation` for each cycle it is seen, and the state does not change.
- R6: A rising edge on event bit i sets `evt_pending[i]`. The bits are: 0 management interrupt, 1 soft init, 2 bus init, 3 local interrupt 0, 4 local interrupt 1. A pending bit produces one pulse on `evt_deliver[i]` in the cycle after a cycle spent in Normal, and then clears, however many times the event occurred.
- R7: The halt strobe moves Normal to AutoHALT. A pending event moves AutoHALT back to Normal, where the event is delivered. A stop-clock request moves AutoHALT to Stop-Grant.
- R8: In Sleep and Deep Sleep, events are not latched. A snoop start there pulses the violation flag and does not change the state. A snoop start together with a sleep request in Stop-Grant also flags a violation and enters Sleep.
- R9: In Sleep, loss of `bclk_present` moves the block to Deep Sleep. In Deep Sleep, its return moves the block back to Sleep.
- R10: Release of the sleep request moves Sleep to Stop-Grant. The release flags a violation if the request was seen for fewer than MIN_SLEEP_CYC (2) cycles, or if the stop-clock request is released in that same cycle.
- R11: A reset request clears pending events and the record of the snoop origin. Stop-Grant stays in Stop-Grant, and every other state, Sleep included, goes to Normal. No violation is flagged while the reset request is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| stopclk_req_n | input | 1 | Stop-clock request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| reset_req_n | input | 1 | Processor reset request, active low |
| halt_stb | input | 1 | Halt instruction strobe |
| snoop_start | input | 1 | Bus snoop start strobe |
| snoop_done | input | 1 | Bus snoop serviced strobe |
| bclk_present | input | 1 | Bus clock running indication |
| evt_in | input | NUM_EVT | Interrupt-type event pins |
| state_oh | output | 6 | One-hot power state |
| core_clk_en | output | 1 | Internal clock enable |
| snoop_resp_en | output | 1 | Snoop response enable |
| evt_pending | output | NUM_EVT | Latched, undelivered events |
| evt_deliver | output | NUM_EVT | One-cycle delivery pulses |
| proto_violation | output | 1 | Protocol violation pulse |

## Verification
The bench compares the design against a reference model on every clock. It probes the corner cases that a faulty design gets wrong:

- **Snoop origin.** A snoop taken from AutoHALT must go back to AutoHALT. A design that loses the origin returns to Stop-Grant instead.
- **Repeated events.** An event repeated in Stop-Grant must be delivered once. A design that delivers it twice, or never, is caught.
- **Sleep release.** A sleep pulse that is too short, and a stop-clock release in the same cycle as the sleep release, must both flag. A design that counts the hold wrongly stays silent on them.
- **Reset request.** Reset in Sleep must go straight to Normal. Reset in Stop-Grant must stay in Stop-Grant and drop the pending events. A design that treats the two alike, or keeps the events, is caught.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int unsigned N_STATES = 6;

    localparam int unsigned I_NORMAL = 0;
    localparam int unsigned I_HALT   = 1;
    localparam int unsigned I_STOPG  = 2;
    localparam int unsigned I_SNOOP  = 3;
    localparam int unsigned I_SLEEP  = 4;
    localparam int unsigned I_DEEP   = 5;

    typedef enum logic [N_STATES-1:0] {
        ST_NORMAL = 6'b000001,
        ST_HALT   = 6'b000010,
        ST_STOPG  = 6'b000100,
        ST_SNOOP  = 6'b001000,
        ST_SLEEP  = 6'b010000,
        ST_DEEP   = 6'b100000
    } pwr_state_e;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pwr_evt_latch.sv
module pwr_evt_latch #(
    parameter int unsigned NUM_EVT = 5
) (
    input  logic               clk,
    input  logic               arst_n,
    input  logic [NUM_EVT-1:0] evt_s,
    input  logic               rst_on,
    input  logic               in_normal,
    input  logic               in_lowpwr,
    output logic [NUM_EVT-1:0] pending,
    output logic [NUM_EVT-1:0] deliver
);
    logic [NUM_EVT-1:0] prev;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        logic rise;
        assign rise = evt_s[i] & ~prev[i] & ~in_lowpwr;

        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                prev[i]    <= 1'b0;
                pending[i] <= 1'b0;
                deliver[i] <= 1'b0;
            end else begin
                prev[i] <= evt_s[i];
                if (rst_on) begin
                    pending[i] <= 1'b0;
                    deliver[i] <= 1'b0;
                end else if (in_normal) begin
                    deliver[i] <= pending[i];
                    pending[i] <= rise;
                end else begin
                    deliver[i] <= 1'b0;
                    pending[i] <= pending[i] | rise;
                end
            end
        end
    end

    // R6
    dlv_only_normal_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (deliver != '0) |-> $past(in_normal));

    // R8
    lowpwr_no_latch_chk: assert property (@(posedge clk) disable iff (!arst_n)
        ($past(in_lowpwr) && !$past(rst_on)) |-> $stable(pending));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_seq_pkg::*;
#(
    parameter int unsigned MIN_SLEEP_CYC = 2
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       stopclk_on,
    input  logic       sleep_on,
    input  logic       rst_on,
    input  logic       halt_s,
    input  logic       snp_start_s,
    input  logic       snp_done_s,
    input  logic       bclk_ok,
    input  logic       pend_any,
    output pwr_state_e state,
    output logic       viol
);
    localparam int unsigned CW = $clog2(MIN_SLEEP_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_SLEEP_CYC);

    pwr_state_e    nxt;
    logic          ret_halt, nxt_ret;
    logic [CW-1:0] cnt, nxt_cnt;
    logic          nxt_viol;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state    <= ST_NORMAL;
            ret_halt <= 1'b0;
            cnt      <= '0;
            viol     <= 1'b0;
        end else begin
            state    <= nxt;
            ret_halt <= nxt_ret;
            cnt      <= nxt_cnt;
            viol     <= nxt_viol;
        end
    end

    always_comb begin
        nxt      = state;
        nxt_ret  = ret_halt;
        nxt_cnt  = cnt;
        nxt_viol = 1'b0;
        if (rst_on) begin
            nxt     = (state == ST_STOPG) ? ST_STOPG : ST_NORMAL;
            nxt_ret = 1'b0;
            nxt_cnt = '0;
        end else begin
            unique case (state)
                ST_NORMAL: begin
                    if (sleep_on)        nxt_viol = 1'b1;
                    else if (stopclk_on) nxt = ST_STOPG;
                    else if (halt_s)     nxt = ST_HALT;
                end
                ST_HALT: begin
                    if (sleep_on) nxt_viol = 1'b1;
                    else if (snp_start_s) begin
                        nxt     = ST_SNOOP;
                        nxt_ret = 1'b1;
                    end
                    else if (stopclk_on) nxt = ST_STOPG;
                    else if (pend_any)   nxt = ST_NORMAL;
                end
                ST_STOPG: begin
                    if (sleep_on) begin
                        nxt      = ST_SLEEP;
                        nxt_cnt  = CW'(1);
                        nxt_viol = snp_start_s;
                    end else if (snp_start_s) begin
                        nxt     = ST_SNOOP;
                        nxt_ret = 1'b0;
                    end else if (!stopclk_on) begin
                        nxt = ST_NORMAL;
                    end
                end
                ST_SNOOP: begin
                    if (sleep_on)        nxt_viol = 1'b1;
                    else if (snp_done_s) nxt = ret_halt ? ST_HALT : ST_STOPG;
                end
                ST_SLEEP: begin
                    if (cnt < CMAX) nxt_cnt = cnt + CW'(1);
                    if (snp_start_s) nxt_viol = 1'b1;
                    if (!bclk_ok) begin
                        nxt = ST_DEEP;
                    end else if (!sleep_on) begin
                        nxt = ST_STOPG;
                        if (cnt < CMAX || !stopclk_on) nxt_viol = 1'b1;
                    end
                end
                ST_DEEP: begin
                    if (cnt < CMAX) nxt_cnt = cnt + CW'(1);
                    if (snp_start_s) nxt_viol = 1'b1;
                    if (bclk_ok) nxt = ST_SLEEP;
                end
                default: nxt = ST_NORMAL;
            endcase
        end
    end

    // R1
    st_onehot_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $countones(state) == 1);

    // R4
    snoop_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(state[I_SNOOP]) |-> ($past(state[I_STOPG]) || $past(state[I_HALT])));

    // R5
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(state[I_SLEEP]) |-> ($past(state[I_STOPG]) || $past(state[I_DEEP])));

    // R9
    deep_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(state[I_DEEP]) |-> $past(state[I_SLEEP]));
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
    import pwr_seq_pkg::*;
#(
    parameter int unsigned NUM_EVT       = 5,
    parameter int unsigned MIN_SLEEP_CYC = 2
) (
    input  logic               clk,
    input  logic               arst_n,
    input  logic               stopclk_req_n,
    input  logic               sleep_req_n,
    input  logic               reset_req_n,
    input  logic               halt_stb,
    input  logic               snoop_start,
    input  logic               snoop_done,
    input  logic               bclk_present,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [5:0]         state_oh,
    output logic               core_clk_en,
    output logic               snoop_resp_en,
    output logic [NUM_EVT-1:0] evt_pending,
    output logic [NUM_EVT-1:0] evt_deliver,
    output logic               proto_violation
);
    localparam int unsigned CTRL_W = 7;
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 7'b111_000_1;

    logic [CTRL_W-1:0]  ctrl_s;
    logic [NUM_EVT-1:0] evt_s;
    pwr_state_e         state;

    pwr_sync #(.W(CTRL_W), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      ({stopclk_req_n, sleep_req_n, reset_req_n,
                  halt_stb, snoop_start, snoop_done, bclk_present}),
        .q      (ctrl_s)
    );

    pwr_sync #(.W(NUM_EVT), .RST_VAL('0)) u_evt_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (evt_in),
        .q      (evt_s)
    );

    pwr_fsm #(.MIN_SLEEP_CYC(MIN_SLEEP_CYC)) u_fsm (
        .clk         (clk),
        .arst_n      (arst_n),
        .stopclk_on  (~ctrl_s[6]),
        .sleep_on    (~ctrl_s[5]),
        .rst_on      (~ctrl_s[4]),
        .halt_s      (ctrl_s[3]),
        .snp_start_s (ctrl_s[2]),
        .snp_done_s  (ctrl_s[1]),
        .bclk_ok     (ctrl_s[0]),
        .pend_any    (|evt_pending),
        .state       (state),
        .viol        (proto_violation)
    );

    pwr_evt_latch #(.NUM_EVT(NUM_EVT)) u_evt (
        .clk       (clk),
        .arst_n    (arst_n),
        .evt_s     (evt_s),
        .rst_on    (~ctrl_s[4]),
        .in_normal (state == ST_NORMAL),
        .in_lowpwr ((state == ST_SLEEP) || (state == ST_DEEP)),
        .pending   (evt_pending),
        .deliver   (evt_deliver)
    );

    always_comb begin
        state_oh      = state;
        core_clk_en   = (state == ST_NORMAL) || (state == ST_HALT);
        snoop_resp_en = (state == ST_STOPG) || (state == ST_HALT) || (state == ST_SNOOP);
    end
endmodule

// File: tb/pwr_state_seq_bench.sv
module pwr_state_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NEV = 5;
    localparam int MINS = 2;
    localparam int WDOG = 20000;
    localparam logic [11:0] IDLE = 12'b111_000_1_00000;

    logic clk = 0;
    logic arst_n = 0;
    logic stopclk_req_n = 1, sleep_req_n = 1, reset_req_n = 1;
    logic halt_stb = 0, snoop_start = 0, snoop_done = 0, bclk_present = 1;
    logic [NEV-1:0] evt_in = '0;
    logic [5:0] state_oh;
    logic core_clk_en, snoop_resp_en, proto_violation;
    logic [NEV-1:0] evt_pending, evt_deliver;

    int total = 0, bad = 0, cyc = 0, vcount = 0;
    int dcount [NEV];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_state_seq #(.NUM_EVT(NEV), .MIN_SLEEP_CYC(MINS)) u_pwr_state_seq (
        .clk(clk), .arst_n(arst_n), .stopclk_req_n(stopclk_req_n),
        .sleep_req_n(sleep_req_n), .reset_req_n(reset_req_n),
        .halt_stb(halt_stb), .snoop_start(snoop_start), .snoop_done(snoop_done),
        .bclk_present(bclk_present), .evt_in(evt_in), .state_oh(state_oh),
        .core_clk_en(core_clk_en), .snoop_resp_en(snoop_resp_en),
        .evt_pending(evt_pending), .evt_deliver(evt_deliver),
        .proto_violation(proto_violation)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: 0 Normal,1 AutoHALT,2 Stop-Grant,3 Snoop,4 Sleep,5 Deep Sleep
    logic [11:0] q[$];
    logic [11:0] d;
    int ms, mcnt;
    bit mret, mviol;
    logic [NEV-1:0] mpend, mdlv, mprev, rise;

    always @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ms = 0; mcnt = 0; mret = 0; mviol = 0;
            mpend = '0; mdlv = '0; mprev = '0;
            q.delete(); q.push_back(IDLE); q.push_back(IDLE);
        end else begin
            bit stp, slp, rst, hlt, ss, sd, bk;
            int n, nc; bit nr, v;
            q.push_back({stopclk_req_n, sleep_req_n, reset_req_n, halt_stb,
                         snoop_start, snoop_done, bclk_present, evt_in});
            d = q.pop_front();
            stp = !d[11]; slp = !d[10]; rst = !d[9]; hlt = d[8];
            ss = d[7]; sd = d[6]; bk = d[5];
            rise = d[4:0] & ~mprev & ((ms >= 4) ? '0 : '1);
            n = ms; nr = mret; nc = mcnt; v = 0;
            if (rst) begin
                n = (ms == 2) ? 2 : 0; nr = 0; nc = 0;
                mdlv = '0; mpend = '0;
            end else begin
                case (ms)
                    0: if (slp) v = 1; else if (stp) n = 2; else if (hlt) n = 1;
                    1: if (slp) v = 1; else if (ss) begin n = 3; nr = 1; end
                       else if (stp) n = 2; else if (mpend != 0) n = 0;
                    2: if (slp) begin n = 4; nc = 1; v = ss; end
                       else if (ss) begin n = 3; nr = 0; end else if (!stp) n = 0;
                    3: if (slp) v = 1; else if (sd) n = mret ? 1 : 2;
                    4: begin
                        if (mcnt < MINS) nc = mcnt + 1;
                        if (ss) v = 1;
                        if (!bk) n = 5;
                        else if (!slp) begin n = 2; if (mcnt < MINS || !stp) v = 1; end
                    end
                    default: begin
                        if (mcnt < MINS) nc = mcnt + 1;
                        if (ss) v = 1;
                        if (bk) n = 4;
                    end
                endcase
                if (ms == 0) begin mdlv = mpend; mpend = rise; end
                else begin mdlv = '0; mpend = mpend | rise; end
            end
            mprev = d[4:0];
            ms = n; mret = nr; mcnt = nc; mviol = v;
        end
    end

    always @(negedge clk) begin
        if (arst_n) begin
            check("R2 state vs model", int'(state_oh), int'(6'b1 << ms));
            check("R3 core_clk_en vs model", int'(core_clk_en), (ms <= 1) ? 1 : 0);
            check("R3 snoop_resp_en vs model", int'(snoop_resp_en), (ms >= 1 && ms <= 3) ? 1 : 0);
            check("R6 pending vs model", int'(evt_pending), int'(mpend));
            check("R6 deliver vs model", int'(evt_deliver), int'(mdlv));
            check("R5 violation vs model", int'(proto_violation), int'(mviol));
            if (proto_violation) vcount++;
            for (int i = 0; i < NEV; i++) if (evt_deliver[i]) dcount[i]++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, WDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_evt(int i);
        evt_in[i] = 1; waitn(1); evt_in[i] = 0; waitn(1);
    endtask

    initial begin
        int v0;
        for (int i = 0; i < NEV; i++) dcount[i] = 0;
        waitn(3);
        arst_n = 1;
        waitn(1);
        // R1 reset state
        check("R1 reset state", int'(state_oh), 1);
        check("R1 reset pending", int'(evt_pending), 0);
        check("R1 reset violation", int'(proto_violation), 0);
        check("R3 clk_en in Normal", int'(core_clk_en), 1);

        // R2 Normal -> Stop-Grant
        stopclk_req_n = 0; waitn(4);
        check("R2 entered Stop-Grant", int'(state_oh), 4);
        check("R3 snoop_en in Stop-Grant", int'(snoop_resp_en), 1);
        check("R3 clk_en off in Stop-Grant", int'(core_clk_en), 0);

        // R6 latch in Stop-Grant
        pulse_evt(0); pulse_evt(0); pulse_evt(3); waitn(4);
        check("R6 pending latched", int'(evt_pending), 5'b01001);
        check("R6 nothing delivered in Stop-Grant", dcount[0], 0);

        // R4 snoop from Stop-Grant
        snoop_start = 1; waitn(1); snoop_start = 0; waitn(4);
        check("R4 in Snoop", int'(state_oh), 8);
        snoop_done = 1; waitn(1); snoop_done = 0; waitn(4);
        check("R4 back to Stop-Grant", int'(state_oh), 4);

        // R2 release, R6 single delivery
        stopclk_req_n = 1; waitn(6);
        check("R2 back to Normal", int'(state_oh), 1);
        check("R6 event0 delivered once", dcount[0], 1);
        check("R6 event3 delivered once", dcount[3], 1);
        check("R6 pending cleared", int'(evt_pending), 0);

        // R7 AutoHALT and R4 return to AutoHALT
        halt_stb = 1; waitn(1); halt_stb = 0; waitn(4);
        check("R7 in AutoHALT", int'(state_oh), 2);
        snoop_start = 1; waitn(1); snoop_start = 0; waitn(4);
        check("R4 Snoop from AutoHALT", int'(state_oh), 8);
        snoop_done = 1; waitn(1); snoop_done = 0; waitn(4);
        check("R4 returned to AutoHALT", int'(state_oh), 2);
        pulse_evt(1); waitn(6);
        check("R7 event wakes to Normal", int'(state_oh), 1);
        check("R7 event1 delivered", dcount[1], 1);

        // R5 sleep request in Normal
        v0 = vcount;
        sleep_req_n = 0; waitn(4);
        check("R5 state unchanged", int'(state_oh), 1);
        check("R5 violation flagged", int'(vcount > v0), 1);
        sleep_req_n = 1; waitn(4);

        // R5 legal Sleep entry, R8, R9
        stopclk_req_n = 0; waitn(4);
        sleep_req_n = 0; waitn(4);
        check("R5 in Sleep", int'(state_oh), 16);
        check("R3 enables off in Sleep", int'({core_clk_en, snoop_resp_en}), 0);
        pulse_evt(2); waitn(4);
        check("R8 event ignored in Sleep", int'(evt_pending), 0);
        v0 = vcount;
        snoop_start = 1; waitn(1); snoop_start = 0; waitn(4);
        check("R8 snoop in Sleep flagged", int'(vcount > v0), 1);
        check("R8 Sleep kept", int'(state_oh), 16);
        bclk_present = 0; waitn(4);
        check("R9 Deep Sleep", int'(state_oh), 32);
        bclk_present = 1; waitn(4);
        check("R9 back to Sleep", int'(state_oh), 16);

        // R10 legal exit
        v0 = vcount;
        sleep_req_n = 1; waitn(2); stopclk_req_n = 1; waitn(6);
        check("R10 legal exit to Normal", int'(state_oh), 1);
        check("R10 no violation on legal exit", vcount, v0);
        check("R8 event2 never delivered", dcount[2], 0);

        // R10 short sleep
        stopclk_req_n = 0; waitn(4);
        v0 = vcount;
        sleep_req_n = 0; waitn(1); sleep_req_n = 1; waitn(6);
        check("R10 short sleep flagged", int'(vcount > v0), 1);
        check("R10 back in Stop-Grant", int'(state_oh), 4);
        // R10 simultaneous release
        sleep_req_n = 0; waitn(4);
        v0 = vcount;
        sleep_req_n = 1; stopclk_req_n = 1; waitn(6);
        check("R10 same-cycle release flagged", int'(vcount > v0), 1);
        check("R10 ends in Normal", int'(state_oh), 1);

        // R11 reset in Stop-Grant
        stopclk_req_n = 0; waitn(4);
        pulse_evt(4); waitn(4);
        check("R11 event4 pending before reset", int'(evt_pending), 5'b10000);
        reset_req_n = 0; waitn(4);
        check("R11 stays Stop-Grant", int'(state_oh), 4);
        check("R11 pending cleared", int'(evt_pending), 0);
        reset_req_n = 1; waitn(4);
        check("R11 still Stop-Grant after reset", int'(state_oh), 4);
        // R11 reset in Sleep
        sleep_req_n = 0; waitn(4);
        check("R11 in Sleep before reset", int'(state_oh), 16);
        v0 = vcount;
        reset_req_n = 0; waitn(1); sleep_req_n = 1; stopclk_req_n = 1; waitn(4);
        check("R11 reset from Sleep to Normal", int'(state_oh), 1);
        reset_req_n = 1; waitn(4);
        check("R11 Normal after reset", int'(state_oh), 1);
        check("R11 no violation under reset", vcount, v0);
        check("R6 event4 never delivered", dcount[4], 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule